// File: doc/BRIEF.md
# LIN Header Break and Sync Timer

This block sits on the receive line of a slave node on a LIN bus. It finds the header's break field by counting how long the line stays dominant. That count runs on a slow, always-on clock of roughly 131 kHz. Once a break qualifies, the block times the 0x55 synchronization byte with a 16-bit counter on the fast clock, nominally 5 MHz. Software divides the result by the number of bit times spanned to get the baud divisor for a companion UART. The block covers bit rates from 1 to 20 kBaud.

Software programs the block through a small register file on the fast clock. That file holds:
- status flags, cleared by writing 1;
- an enable bit and per-flag interrupt masks;
- the choice of start and stop edges;
- the minimum and maximum break lengths;
- read-only copies of the last break length and of the sync count.

One interrupt line is the OR of the unmasked flags. A receive-enable output keeps the UART deaf while the break and the sync byte are being measured.

Top module: `lin_sync_timer`

## Requirements
- R1: After reset, the status register (address 0) reads 0, the edge register (address 2) reads 0x0051, the break-minimum register (address 5) reads the parameter default, `irq` is low and `uart_rx_en` is high.
- R2: With enable set, a dominant period of at least the break minimum and at most the break maximum (addresses 5 and 6, in slow-clock ticks) sets status bit 0 once the line returns recessive. The break-length register (address 4) then holds the dominant time in slow ticks, within one tick.
- R3: A dominant period of at least half the break minimum but shorter than the minimum sets status bit 3 (break error) on release. A dominant period shorter than half the minimum changes no flag.
- R4: A dominant period that exceeds the break maximum sets status bit 3 while the line is still dominant. The break-length register then reads maximum+1, and the later release sets no break flag.
- R5: After a break, falling edges of the receive line are numbered from 1, where edge 1 is the start bit. The edges chosen by address 2, bits [2:0] for the start and bits [6:4] for the stop, set status bit 1 and status bit 2. The count at address 3 equals the fast-clock cycles between those edges, which is 2*(stop-start) bit periods for a 0x55 byte.
- R6: If the stop edge does not arrive, the sync count saturates at 0xFFFF and status bit 3 is set.
- R7: `uart_rx_en` goes low when a qualified break is flagged and returns high when the stop edge arrives or the counter saturates.
- R8: Writing 1 to a status bit clears only that bit. When the same bit is set by hardware in the same cycle, the set wins.
- R9: `irq` is high exactly when some status bit k is set and its mask bit, control (address 1) bit k+1, is set.
- R10: With control bit 0 (enable) clear, dominant periods raise no flag and `uart_rx_en` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock for sync timing and register access |
| brk_clk | input | 1 | Slow clock for break timing |
| rst_n | input | 1 | Asynchronous active-low reset |
| lin_rx | input | 1 | Receive line from the transceiver, low is dominant |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational on address |
| irq | output | 1 | Interrupt, OR of unmasked status flags |
| uart_rx_en | output | 1 | High when the UART may receive |

## Verification
The stop edge of the sync byte and a software write that clears the stop flag can land on the same fast-clock edge. In that case the new event must survive. The bench provokes this by counting the two synchronizer stages and the edge register after the stop edge is driven. It then holds the write strobe so that it is sampled on exactly that edge. The status read afterwards must still show the stop flag, together with the full sync count.

// File: rtl/lin_sync_timer.sv
`timescale 1ns/1ps
module lin_sync_timer #(
  parameter int CW          = 16,
  parameter int BW          = 16,
  parameter int DW          = 16,
  parameter int BRK_MIN_RST = 1442,
  parameter int BRK_MAX_RST = 5000
) (
  input  logic          clk,
  input  logic          brk_clk,
  input  logic          rst_n,
  input  logic          lin_rx,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  output logic          uart_rx_en
);
  localparam logic [2:0] A_STS = 3'd0, A_CTL = 3'd1, A_EDG = 3'd2, A_CNT = 3'd3,
                         A_LEN = 3'd4, A_MIN = 3'd5, A_MAX = 3'd6;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_CNT} st_t;

  // register file (fast domain)
  logic [3:0]    sts;
  logic [4:0]    ctl;
  logic [2:0]    e_start, e_stop;
  logic [BW-1:0] bmin, bmax;
  logic [BW-1:0] blen_f;
  logic [CW-1:0] scnt;
  wire en = ctl[0];

  // slow domain: break qualification
  logic [1:0]    bs, be;
  logic [BW-1:0] bcnt, blen;
  logic          ok_t, er_t, long_sent;
  wire brx = bs[1];
  wire ben = be[1];

  always_ff @(posedge brk_clk or negedge rst_n) begin
    if (!rst_n) begin
      bs <= 2'b11;
      be <= 2'b00;
    end else begin
      bs <= {bs[0], lin_rx};
      be <= {be[0], en};
    end
  end

  always_ff @(posedge brk_clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt      <= '0;
      blen      <= '0;
      ok_t      <= 1'b0;
      er_t      <= 1'b0;
      long_sent <= 1'b0;
    end else if (!ben) begin
      bcnt      <= '0;
      long_sent <= 1'b0;
    end else if (!brx) begin
      if (bcnt != '1) bcnt <= bcnt + 1'b1;
      if (bcnt == bmax && !long_sent) begin
        long_sent <= 1'b1;
        er_t      <= ~er_t;
        blen      <= bcnt + 1'b1;
      end
    end else if (bcnt != '0) begin
      bcnt      <= '0;
      long_sent <= 1'b0;
      if (!long_sent) begin
        if (bcnt >= bmin) begin
          ok_t <= ~ok_t;
          blen <= bcnt;
        end else if (bcnt >= (bmin >> 1)) begin
          er_t <= ~er_t;
          blen <= bcnt;
        end
      end
    end
  end

  // fast domain: synchronizers
  logic [2:0] rs, ok_s, er_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs   <= 3'b111;
      ok_s <= 3'b000;
      er_s <= 3'b000;
    end else begin
      rs   <= {rs[1:0], lin_rx};
      ok_s <= {ok_s[1:0], ok_t};
      er_s <= {er_s[1:0], er_t};
    end
  end
  wire fall  = rs[2] & ~rs[1];
  wire ok_ev = ok_s[2] ^ ok_s[1];
  wire er_ev = er_s[2] ^ er_s[1];

  // fast domain: sync byte measurement
  st_t           st, st_n;
  logic [2:0]    ecnt, ecnt_n;
  logic [CW-1:0] scnt_n;
  logic          ev_start, ev_stop, ev_ovf;
  wire  [2:0]    ecnt_inc = 3'(ecnt + 3'd1);

  always_comb begin
    st_n     = st;
    ecnt_n   = ecnt;
    scnt_n   = scnt;
    ev_start = 1'b0;
    ev_stop  = 1'b0;
    ev_ovf   = 1'b0;
    if (!en) begin
      st_n = S_IDLE;
    end else if (ok_ev) begin
      st_n   = S_WAIT;
      ecnt_n = '0;
    end else begin
      case (st)
        S_WAIT: if (fall) begin
          ecnt_n = ecnt_inc;
          if (ecnt_inc == e_start) begin
            st_n     = S_CNT;
            scnt_n   = '0;
            ev_start = 1'b1;
          end
        end
        S_CNT: begin
          if (fall) ecnt_n = ecnt_inc;
          if (scnt == '1) begin
            st_n   = S_IDLE;
            ev_ovf = 1'b1;
          end else begin
            scnt_n = scnt + 1'b1;
            if (fall && ecnt_inc == e_stop) begin
              st_n    = S_IDLE;
              ev_stop = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      ecnt <= '0;
      scnt <= '0;
    end else begin
      st   <= st_n;
      ecnt <= ecnt_n;
      scnt <= scnt_n;
    end
  end

  // registers
  wire [3:0] sts_set = {er_ev | ev_ovf, ev_stop, ev_start, ok_ev};
  wire [3:0] sts_clr = (reg_we && reg_addr == A_STS) ? reg_wdata[3:0] : 4'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts     <= '0;
      ctl     <= '0;
      e_start <= 3'd1;
      e_stop  <= 3'd5;
      bmin    <= BW'(BRK_MIN_RST);
      bmax    <= BW'(BRK_MAX_RST);
      blen_f  <= '0;
    end else begin
      sts <= (sts & ~sts_clr) | sts_set;
      if (ok_ev || er_ev) blen_f <= blen;
      if (reg_we) begin
        case (reg_addr)
          A_CTL: ctl <= reg_wdata[4:0];
          A_EDG: begin
            e_start <= reg_wdata[2:0];
            e_stop  <= reg_wdata[6:4];
          end
          A_MIN: bmin <= reg_wdata[BW-1:0];
          A_MAX: bmax <= reg_wdata[BW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_STS:   reg_rdata = DW'(sts);
      A_CTL:   reg_rdata = DW'(ctl);
      A_EDG:   reg_rdata = DW'({e_stop, 1'b0, e_start});
      A_CNT:   reg_rdata = DW'(scnt);
      A_LEN:   reg_rdata = DW'(blen_f);
      A_MIN:   reg_rdata = DW'(bmin);
      A_MAX:   reg_rdata = DW'(bmax);
      default: reg_rdata = '0;
    endcase
  end

  assign irq        = |(sts & ctl[4:1]);
  assign uart_rx_en = (st == S_IDLE);

  // assertions
  assert_stop_needs_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[2]) |-> $past(st) == S_CNT);

  assert_count_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CNT && $past(st) == S_CNT) |-> scnt == CW'($past(scnt) + 1'b1));

  assert_saturate_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CNT && scnt == '1 && en && !ok_ev) |=> (sts[3] && st == S_IDLE && scnt == '1));

  assert_gate_after_break_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uart_rx_en) |-> sts[0]);

  assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_STS && reg_wdata[1] && !ev_start) |=> !sts[1]);
endmodule

// File: tb/lin_sync_timer_test.sv
`timescale 1ns/1ps
module lin_sync_timer_test;
  logic clk = 1'b0, brk_clk = 1'b0, rst_n = 1'b0, lin_rx = 1'b1;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'd0, reg_rdata;
  logic irq, uart_rx_en;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  lin_sync_timer uut (.clk(clk), .brk_clk(brk_clk), .rst_n(rst_n), .lin_rx(lin_rx),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .uart_rx_en(uart_rx_en));

  always #4 clk = ~clk;
  always #152 brk_clk = ~brk_clk;

  // start edge, stop edge, bit period in fast cycles, expected count
  localparam int VEC [4][4] = '{'{1, 5, 40, 320}, '{2, 4, 30, 120},
                                '{1, 2, 25, 50},  '{3, 5, 20, 80}};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic brk(input int ticks);
    @(negedge clk); lin_rx = 1'b0;
    repeat (ticks) @(posedge brk_clk);
    @(negedge clk); lin_rx = 1'b1;
    repeat (200) @(negedge clk);
  endtask

  function automatic logic sync_bit(input int i);
    if (i == 0) return 1'b0;
    if (i == 9) return 1'b1;
    return 1'((8'h55 >> (i - 1)) & 1);
  endfunction

  task automatic sync_byte(input int bt, input bit clash);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); lin_rx = sync_bit(i);
      if (clash && i == 8) begin
        @(negedge clk);
        @(negedge clk); reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 16'h0004;
        @(negedge clk); reg_we = 1'b0;
        repeat (bt - 4) @(negedge clk);
      end else begin
        repeat (bt - 1) @(negedge clk);
      end
    end
    repeat (20) @(negedge clk);
  endtask

  initial begin
    #(8ns * 190000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3'd0, v); chk("R1 status", v, 16'h0);
    rd(3'd2, v); chk("R1 edges", v, 16'h0051);
    rd(3'd5, v); chk("R1 brk min", v, 16'd1442);
    chk("R1 irq", irq, 1'b0);
    chk("R1 rx_en", uart_rx_en, 1'b1);

    wr(3'd5, 16'd20);
    wr(3'd6, 16'd60);
    // R10 disabled: break ignored
    wr(3'd1, 16'h001E);
    brk(30);
    rd(3'd0, v); chk("R10 no flags when disabled", v, 16'h0);
    chk("R10 rx_en", uart_rx_en, 1'b1);
    wr(3'd1, 16'h001F);
    repeat (10) @(posedge brk_clk);

    for (int k = 0; k < 4; k++) begin
      wr(3'd2, 16'(VEC[k][0] | (VEC[k][1] << 4)));
      brk(30);
      rd(3'd0, v); chk("R2 break flag", v, 16'h1);
      rd(3'd4, v); chk_rng("R2 break length", int'(v), 29, 31);
      chk("R7 rx gated after break", uart_rx_en, 1'b0);
      sync_byte(VEC[k][2], 1'b0);
      rd(3'd0, v); chk("R5 start/stop flags", v, 16'h7);
      rd(3'd3, v); chk("R5 sync count", v, 16'(VEC[k][3]));
      chk("R7 rx released after stop", uart_rx_en, 1'b1);
      chk("R9 irq all masked in", irq, 1'b1);
      wr(3'd0, 16'h000F);
      rd(3'd0, v); chk("R8 clear all", v, 16'h0);
      chk("R9 irq low when clear", irq, 1'b0);
    end

    // R3 glitch below half minimum ignored
    brk(5);
    rd(3'd0, v); chk("R3 short glitch ignored", v, 16'h0);
    // R3 short break error
    brk(15);
    rd(3'd0, v); chk("R3 short break error", v, 16'h8);
    rd(3'd4, v); chk_rng("R3 short length", int'(v), 14, 16);
    wr(3'd0, 16'h000F);

    // R4 too long
    @(negedge clk); lin_rx = 1'b0;
    repeat (66) @(posedge brk_clk);
    rd(3'd0, v); chk("R4 error while dominant", v, 16'h8);
    chk("R4 rx not gated", uart_rx_en, 1'b1);
    @(negedge clk); lin_rx = 1'b1;
    repeat (200) @(negedge clk);
    rd(3'd0, v); chk("R4 no break on release", v, 16'h8);
    rd(3'd4, v); chk("R4 length max+1", v, 16'd61);
    wr(3'd0, 16'h000F);

    // R9 masking: only the error mask set
    wr(3'd1, 16'h0011);
    wr(3'd2, 16'h0051);
    brk(30);
    rd(3'd0, v); chk("R9 break flag", v, 16'h1);
    chk("R9 irq masked", irq, 1'b0);
    wr(3'd1, 16'h0013);
    @(negedge clk); chk("R9 irq unmasked", irq, 1'b1);
    // R8 same-cycle clear and set of the stop flag
    sync_byte(40, 1'b1);
    rd(3'd0, v); chk("R8 set wins over clear", v, 16'h7);
    rd(3'd3, v); chk("R5 count during clash", v, 16'd320);
    wr(3'd0, 16'h0002);
    rd(3'd0, v); chk("R8 single-bit clear", v, 16'h5);
    wr(3'd0, 16'h000F);

    // R6 overflow: stop edge 7 never arrives
    wr(3'd1, 16'h001F);
    wr(3'd2, 16'h0071);
    brk(30);
    sync_byte(10, 1'b0);
    chk("R7 gated while counting", uart_rx_en, 1'b0);
    repeat (65600) @(negedge clk);
    rd(3'd0, v); chk("R6 overflow flags", v, 16'hB);
    rd(3'd3, v); chk("R6 saturated count", v, 16'hFFFF);
    chk("R7 released after overflow", uart_rx_en, 1'b1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule